// File: doc/BRIEF.md
# TPC Hit-Pattern Level-2 Trigger

This block makes the level-2 accept/reject decision for a time projection chamber event. Its input is a small bitmap of macropad blocks, one bit per block, where a set bit means that the block of pads fired. The block runs only after the level-1 multiplicity stage has accepted the event. It copies the bitmap, the index of the row that lies under the beam projection and a minimum track length into internal registers. It then walks the grid one block per clock and produces a single accept or reject together with a one-cycle done strobe.

Three geometric tests set the verdict. Blocks off the beam row are called track blocks. The first test measures the longest run of horizontally adjacent track blocks. The second counts the occupied blocks on the beam row. The third traces an integer straight line between the first and the last track block in row-major order. It then asks whether that line passes through another track block. The worst-case latency is the grid size plus one row plus one line trace. That is a few hundred cycles, which is far inside a budget of tens of microseconds.

Top module: `hp_l2_trigger`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle, and `busy`, `done`, `accept` and `overrun` read 0 after that edge.
- R2: A start is a rising edge at which `l1_accept` is 1 and the block is idle. At a start the block captures `hit_map` (bit index row*COLS+col, row 0 first), `beam_row` and `min_run`. `busy` then stays 1 until the done cycle has passed. The done cycle comes ROWS*COLS+COLS edges after the start edge, plus L edges when the line trace of R7 runs.
- R3: `done` is 1 for exactly one cycle per event. `accept` becomes 0 at a start, takes the verdict in the done cycle, and then holds until the next start.
- R4: If no block on the captured beam row is set, the event is accepted.
- R5: If two or more blocks on the beam row are set, the event is rejected.
- R6: If exactly one beam-row block is set, the event is accepted when the longest run of horizontally adjacent track blocks is at least `min_run`. A run never continues from the last column of one row into the next row, and beam-row blocks never count towards a run. A `min_run` of 0 always passes.
- R7: Otherwise, the event is rejected if it has fewer than two track blocks. If it has two or more, a line is traced from the first to the last track block in row-major order, with x as the column and y as the row. The trace starts from dx=|x1-x0|, dy=-|y1-y0| and err=dx+dy. Each step sets e2=2*err. When e2>=dy, it adds dy to err and moves x one step towards x1. When e2<=dx, it adds dx to err and moves y one step towards y1. Tracing stops on reaching the end point, after L steps. The event is accepted only if a point other than the end point is a track block.
- R8: A `l1_accept` pulse that arrives while `busy` is 1 does not restart the event and does not change the verdict. It sets `overrun`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l1_accept | input | 1 | Level-1 accept pulse that starts an evaluation |
| hit_map | input | ROWS*COLS | Block bitmap, bit row*COLS+col set for a fired block |
| beam_row | input | $clog2(ROWS) | Index of the row under the beam projection |
| min_run | input | $clog2(COLS+1) | Minimum horizontal run length that counts as a track |
| busy | output | 1 | Evaluation in progress, including the done cycle |
| done | output | 1 | One-cycle strobe marking the verdict |
| accept | output | 1 | Verdict: 1 accept, 0 reject |
| overrun | output | 1 | Sticky flag for a start pulse received while busy |

## Verification
The bench builds the block with its default 16-column by 8-row grid. This makes the row-end boundary of the run measure reachable, and it allows lines long enough to give trace lengths of up to 15 steps. Beam rows at the top edge, the bottom edge and the interior are all exercised. The same bitmap is run with two different `min_run` values, so that one event is settled by the run test and the other by the line trace. A mid-event start pulse that also changes the live inputs shows that the captured values are the ones used.

// File: rtl/hp_l2_pkg.sv
// Shared types for the level-2 hit-pattern trigger.
// Assumes: one-hot state encoding is wanted for shallow next-state decode.
package hp_l2_pkg;

    typedef enum logic [4:0] {
        ST_IDLE = 5'b00001,
        ST_CONT = 5'b00010,
        ST_ORIG = 5'b00100,
        ST_LINE = 5'b01000,
        ST_DONE = 5'b10000
    } hp_state_e;

endpackage

// File: rtl/hp_run_scan.sv
// Row-major scanner for track blocks. It takes one block per enabled cycle.
// It tracks the longest horizontal run, which restarts at every row end.
// It also records the first and last set block, and counts set blocks up to a limit of 2.
// Assumes: the caller presents blocks in row-major order and pulses clear at the start of an event.
module hp_run_scan #(
    parameter int COLS = 16,
    parameter int ROWS = 8,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int NW = $clog2(COLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          bit_in,
    input  logic          row_end,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic [NW-1:0] max_run,
    output logic [1:0]    blk_cnt,
    output logic [RW-1:0] first_row,
    output logic [CW-1:0] first_col,
    output logic [RW-1:0] last_row,
    output logic [CW-1:0] last_col
);

    logic [NW-1:0] cur_q;
    logic [NW-1:0] cur_inc;

    // Length of the current run if this block extends it.
    assign cur_inc = cur_q + 1'b1;

    // Run, extreme and count bookkeeping, one block per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_q     <= '0;
            max_run   <= '0;
            blk_cnt   <= '0;
            first_row <= '0;
            first_col <= '0;
            last_row  <= '0;
            last_col  <= '0;
        end else if (en) begin
            if (bit_in) begin
                if (cur_inc > max_run) begin
                    max_run <= cur_inc;
                end
                cur_q <= row_end ? '0 : cur_inc;
                if (blk_cnt == 2'd0) begin
                    first_row <= row;
                    first_col <= col;
                end
                last_row <= row;
                last_col <= col;
                if (blk_cnt != 2'd2) begin
                    blk_cnt <= blk_cnt + 2'd1;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

    // A run can never be longer than one row.
    assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (max_run <= NW'(COLS)));

endmodule

// File: rtl/hp_line_step.sv
// Integer line stepper. It walks from a start block to an end block, one grid point per step.
// It latches a hit flag when a point other than the end point falls on a set bit of the map.
// Assumes: load happens one cycle before the first step, and the end point differs from the start point.
module hp_line_step #(
    parameter int COLS = 16,
    parameter int ROWS = 8,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int N  = COLS * ROWS,
    localparam int IW = $clog2(N),
    localparam int DW = ((CW > RW) ? CW : RW) + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] x0,
    input  logic [RW-1:0] y0,
    input  logic [CW-1:0] x1,
    input  logic [RW-1:0] y1,
    input  logic [N-1:0]  map,
    output logic          hit,
    output logic          last_step
);

    logic signed [DW-1:0] x_q, y_q, ex_q, ey_q, dx_q, dy_q, err_q;
    logic                 sx_neg_q, sy_neg_q;
    logic signed [DW-1:0] lx0, ly0, lx1, ly1, ldx, ldy;
    logic signed [DW-1:0] e2, nx, ny, nerr;
    logic [IW-1:0]        nidx;

    // Widen the endpoint coordinates to signed values.
    assign lx0 = $signed({{(DW-CW){1'b0}}, x0});
    assign ly0 = $signed({{(DW-RW){1'b0}}, y0});
    assign lx1 = $signed({{(DW-CW){1'b0}}, x1});
    assign ly1 = $signed({{(DW-RW){1'b0}}, y1});
    assign ldx = (lx1 >= lx0) ? (lx1 - lx0) : (lx0 - lx1);
    assign ldy = (ly1 >= ly0) ? (ly0 - ly1) : (ly1 - ly0);

    // Next point and error term for one step.
    always_comb begin
        e2   = err_q <<< 1;
        nx   = x_q;
        ny   = y_q;
        nerr = err_q;
        if (e2 >= dy_q) begin
            nerr = nerr + dy_q;
            nx   = sx_neg_q ? (x_q - 1'b1) : (x_q + 1'b1);
        end
        if (e2 <= dx_q) begin
            nerr = nerr + dx_q;
            ny   = sy_neg_q ? (y_q - 1'b1) : (y_q + 1'b1);
        end
    end

    // Map index of the next point and detection of the end point.
    assign nidx      = IW'(ny[RW-1:0]) * IW'(COLS) + IW'(nx[CW-1:0]);
    assign last_step = (nx == ex_q) && (ny == ey_q);

    // Stepper registers: set up on load, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0; y_q <= '0; ex_q <= '0; ey_q <= '0;
            dx_q <= '0; dy_q <= '0; err_q <= '0;
            sx_neg_q <= 1'b0; sy_neg_q <= 1'b0;
            hit <= 1'b0;
        end else if (load) begin
            x_q      <= lx0;
            y_q      <= ly0;
            ex_q     <= lx1;
            ey_q     <= ly1;
            dx_q     <= ldx;
            dy_q     <= ldy;
            err_q    <= ldx + ldy;
            sx_neg_q <= (lx1 < lx0);
            sy_neg_q <= (ly1 < ly0);
            hit      <= 1'b0;
        end else if (step) begin
            x_q   <= nx;
            y_q   <= ny;
            err_q <= nerr;
            if (!last_step && map[nidx]) begin
                hit <= 1'b1;
            end
        end
    end

    // Every step keeps the point inside the grid.
    assert_step_in_grid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (nx >= 0 && nx < COLS && ny >= 0 && ny < ROWS));

endmodule

// File: rtl/hp_l2_trigger.sv
// Level-2 hit-pattern trigger top.
// It captures the block bitmap on a level-1 accept and scans the track blocks for the run test.
// It then scans the beam row and, when needed, traces a line between the extreme track blocks.
// Assumes: COLS and ROWS are at least 2, and beam_row is below ROWS.
module hp_l2_trigger
    import hp_l2_pkg::*;
#(
    parameter int COLS = 16,
    parameter int ROWS = 8,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int NW = $clog2(COLS + 1),
    localparam int N  = COLS * ROWS,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l1_accept,
    input  logic [N-1:0]  hit_map,
    input  logic [RW-1:0] beam_row,
    input  logic [NW-1:0] min_run,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          overrun
);

    hp_state_e     state_q;
    logic [N-1:0]  snap_q;
    logic [N-1:0]  track_map;
    logic [RW-1:0] beam_q;
    logic [NW-1:0] minrun_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [1:0]    beam_cnt_q, beam_cnt_nxt;
    logic          start, row_end, cont_bit, orig_bit, go_line;
    logic [NW-1:0] max_run;
    logic [1:0]    blk_cnt;
    logic [RW-1:0] first_row, last_row;
    logic [CW-1:0] first_col, last_col;
    logic          line_hit, line_last;

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign start    = (state_q == ST_IDLE) && l1_accept;
    assign row_end  = (col_q == CW'(COLS - 1));
    assign cont_bit = track_map[IW'(row_q) * IW'(COLS) + IW'(col_q)];
    assign orig_bit = snap_q[IW'(beam_q) * IW'(COLS) + IW'(col_q)];

    // Track map: the captured bitmap with the beam row blanked, built row by row.
    for (genvar r = 0; r < ROWS; r++) begin : g_track_row
        assign track_map[r*COLS +: COLS] = (beam_q == RW'(r)) ? '0 : snap_q[r*COLS +: COLS];
    end

    // Beam-row occupancy including the block scanned this cycle, limited to 2.
    assign beam_cnt_nxt = (orig_bit && beam_cnt_q != 2'd2) ? beam_cnt_q + 2'd1 : beam_cnt_q;

    // A line trace is needed only when the other tests leave the verdict open.
    assign go_line = (state_q == ST_ORIG) && row_end && (beam_cnt_nxt == 2'd1)
                     && (max_run < minrun_q) && (blk_cnt == 2'd2);

    hp_run_scan #(.COLS(COLS), .ROWS(ROWS)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .en        (state_q == ST_CONT),
        .bit_in    (cont_bit),
        .row_end   (row_end),
        .row       (row_q),
        .col       (col_q),
        .max_run   (max_run),
        .blk_cnt   (blk_cnt),
        .first_row (first_row),
        .first_col (first_col),
        .last_row  (last_row),
        .last_col  (last_col)
    );

    hp_line_step #(.COLS(COLS), .ROWS(ROWS)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_line),
        .step      (state_q == ST_LINE),
        .x0        (first_col),
        .y0        (first_row),
        .x1        (last_col),
        .y1        (last_row),
        .map       (track_map),
        .hit       (line_hit),
        .last_step (line_last)
    );

    // Sequencer: capture, continuity scan, beam-row scan, line trace, verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            snap_q     <= '0;
            beam_q     <= '0;
            minrun_q   <= '0;
            row_q      <= '0;
            col_q      <= '0;
            beam_cnt_q <= '0;
            accept     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (l1_accept) begin
                        snap_q     <= hit_map;
                        beam_q     <= beam_row;
                        minrun_q   <= min_run;
                        row_q      <= '0;
                        col_q      <= '0;
                        beam_cnt_q <= '0;
                        accept     <= 1'b0;
                        state_q    <= ST_CONT;
                    end
                end
                ST_CONT: begin
                    if (row_end) begin
                        col_q <= '0;
                        if (row_q == RW'(ROWS - 1)) begin
                            state_q <= ST_ORIG;
                        end else begin
                            row_q <= row_q + 1'b1;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_ORIG: begin
                    beam_cnt_q <= beam_cnt_nxt;
                    col_q      <= col_q + 1'b1;
                    if (row_end) begin
                        if (go_line) begin
                            state_q <= ST_LINE;
                        end else begin
                            state_q <= ST_DONE;
                            if (beam_cnt_nxt == 2'd0) begin
                                accept <= 1'b1;
                            end else if (beam_cnt_nxt == 2'd2) begin
                                accept <= 1'b0;
                            end else begin
                                accept <= (max_run >= minrun_q);
                            end
                        end
                    end
                end
                ST_LINE: begin
                    if (line_last) begin
                        accept  <= line_hit;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Sticky flag for start pulses that arrive while an evaluation is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (l1_accept && busy) begin
            overrun <= 1'b1;
        end
    end

    assert_onehot_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q) && state_q != 5'b00000);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && l1_accept) |=> (busy && !accept));
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_accept_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !l1_accept) |=> $stable(accept));
    assert_beam_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && beam_cnt_q == 2'd0) |-> accept);
    assert_beam_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && beam_cnt_q == 2'd2) |-> !accept);
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && l1_accept) |=> overrun);

endmodule

// File: tb/tb_hp_l2_trigger.sv
// Self-checking bench with a behavioural reference model, compared on every clock.
module tb_hp_l2_trigger;

    localparam int COLS = 16;
    localparam int ROWS = 8;
    localparam int N    = COLS * ROWS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         l1_accept = 1'b0;
    logic [N-1:0] hit_map = '0;
    logic [2:0]   beam_row = '0;
    logic [4:0]   min_run = '0;
    logic         busy, done, accept, overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_ovr = 0;
    bit finished = 0;
    logic [N-1:0] m;

    always #10ns clk = ~clk;

    hp_l2_trigger #(.COLS(COLS), .ROWS(ROWS)) dut (
        .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept), .hit_map(hit_map),
        .beam_row(beam_row), .min_run(min_run),
        .busy(busy), .done(done), .accept(accept), .overrun(overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int r, input int c);
        m[r*COLS + c] = 1'b1;
    endtask

    // Reference verdict and latency computed from the requirements.
    task automatic model(input logic [N-1:0] mp, input int beam, input int minr,
                         output bit acc, output int lat);
        bit tr [ROWS][COLS];
        int run = 0, maxr = 0, cnt = 0, bc = 0;
        int fr = 0, fc = 0, lr = 0, lc = 0;
        lat = N + COLS;
        for (int r = 0; r < ROWS; r++) begin
            run = 0;
            for (int c = 0; c < COLS; c++) begin
                tr[r][c] = mp[r*COLS + c] && (r != beam);
                if (tr[r][c]) begin
                    run++;
                    if (run > maxr) maxr = run;
                    if (cnt == 0) begin fr = r; fc = c; end
                    lr = r; lc = c;
                    cnt++;
                end else begin
                    run = 0;
                end
            end
        end
        for (int c = 0; c < COLS; c++) if (mp[beam*COLS + c]) bc++;
        if (bc == 0)            acc = 1;
        else if (bc >= 2)       acc = 0;
        else if (maxr >= minr)  acc = 1;
        else if (cnt < 2)       acc = 0;
        else begin
            int x = fc, y = fr, dx, dy, sx, sy, err, e2, steps = 0;
            bit hit = 0;
            dx = (lc > fc) ? lc - fc : fc - lc;
            dy = (lr > fr) ? fr - lr : lr - fr;
            sx = (lc < fc) ? -1 : 1;
            sy = (lr < fr) ? -1 : 1;
            err = dx + dy;
            while (!(x == lc && y == lr)) begin
                e2 = 2 * err;
                if (e2 >= dy) begin err += dy; x += sx; end
                if (e2 <= dx) begin err += dx; y += sy; end
                steps++;
                if (!(x == lc && y == lr) && tr[y][x]) hit = 1;
            end
            lat += steps;
            acc = hit;
        end
    endtask

    // Run one event and compare every cycle; inj >= 0 sends an extra start at that sample.
    task automatic run_event(input logic [N-1:0] mp, input int beam, input int minr,
                             input int inj, input string req);
        bit acc;
        int lat;
        model(mp, beam, minr, acc, lat);
        @(negedge clk);
        hit_map = mp; beam_row = 3'(beam); min_run = 5'(minr); l1_accept = 1'b1;
        @(negedge clk);
        l1_accept = 1'b0;
        for (int j = 0; j <= lat + 4; j++) begin
            if (j > 0) begin
                @(negedge clk);
                l1_accept = 1'b0;
            end
            chk("R2", "busy", int'(busy), int'(j <= lat));
            chk("R3", "done", int'(done), int'(j == lat));
            chk("R8", "overrun", int'(overrun), int'(exp_ovr));
            if (j < lat) chk("R3", "accept cleared during event", int'(accept), 0);
            else         chk(req, "verdict", int'(accept), int'(acc));
            if (j == inj) begin
                l1_accept = 1'b1;
                hit_map = '1;
                beam_row = 3'd5;
                exp_ovr = 1;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "accept in reset", int'(accept), 0);
        chk("R1", "overrun in reset", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: empty map, beam row empty.
        m = '0;
        run_event(m, 3, 4, -1, "R4");
        // R4: tracks present but beam row still empty.
        m = '0; put(1, 0); put(6, 9);
        run_event(m, 7, 4, -1, "R4");
        // R5: two beam-row blocks at different columns.
        m = '0; put(3, 2); put(3, 9); put(5, 1); put(5, 2); put(5, 3); put(5, 4);
        run_event(m, 3, 2, -1, "R5");
        // R6: run of 5 meets min_run 5; mid-event start checks R8.
        m = '0; put(3, 5); for (int c = 2; c <= 6; c++) put(5, c);
        run_event(m, 3, 5, 20, "R6");
        // R7: same map with min_run 6 falls to the line trace, which crosses blocks.
        run_event(m, 3, 6, -1, "R7");
        // R7: two isolated blocks with nothing between them, beam at row 0.
        m = '0; put(0, 4); put(1, 0); put(7, 15);
        run_event(m, 0, 2, -1, "R7");
        // R7: diagonal through a middle block, beam at row 7.
        m = '0; put(7, 10); put(0, 0); put(3, 3); put(6, 6);
        run_event(m, 7, 2, -1, "R7");
        // R6: a run does not carry across the row end, and the trace finds no crossing.
        m = '0; put(4, 0); put(2, 14); put(2, 15); put(3, 0); put(3, 1);
        run_event(m, 4, 3, -1, "R6");
        // R7: a single track block cannot form a line.
        m = '0; put(0, 0); put(5, 5);
        run_event(m, 0, 2, -1, "R7");
        // R6: min_run of 0 always passes.
        m = '0; put(2, 8);
        run_event(m, 2, 0, -1, "R6");
        // R1: reset clears the sticky flag and the verdict.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "overrun after reset", int'(overrun), 0);
        chk("R1", "accept after reset", int'(accept), 0);
        rst_n = 1'b1; exp_ovr = 0;

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule